// File: doc/BRIEF.md
# Clock-Crossing Word Bridge with Valid/Ready Handshakes

This block carries single data words from one clock domain to another when the two clocks are unrelated. On each side it offers an ordinary level-based valid/ready interface. A word moves on the source side whenever `s_valid` and `s_ready` are both high on a source clock edge. It then appears on `m_data` with `m_valid` high, and it stays there until the consumer takes it with `m_ready`.

Internally the bridge holds exactly one word. Each side owns a single toggle bit. The source inverts its bit when it accepts a word, and the destination inverts its bit when it hands a word over. Each bit reaches the other domain through a chain of flip-flops whose depth is a parameter. A side compares its own bit with the copy it has received from the other side. Equal bits mean the source is free to take a word. Unequal bits mean the destination holds a pending word. The word register itself is not synchronised bit by bit: it is only sampled in the destination domain while the handshake guarantees that it is held still. The same logic serves any ratio of the two clock frequencies.

Top module: `hs_cdc_bridge`

## Requirements
- R1: After reset of both domains, `s_ready` is 1 and `m_valid` is 0.
- R2: A source transfer happens on an `s_clk` edge where `s_valid` and `s_ready` are both 1. `s_ready` is 0 in the source cycle that directly follows that edge.
- R3: After a transfer, `s_ready` stays 0 until the destination has handed the word over and that acknowledgement has crossed back. It then returns to 1. At most one word is in flight at any time.
- R4: Every accepted word appears on `m_data` with `m_valid` at 1. Words arrive in acceptance order, with their value unchanged.
- R5: While `m_valid` is 1 and `m_ready` is 0, both `m_valid` and `m_data` hold their values on the next `m_clk` edge.
- R6: After an `m_clk` edge where `m_valid` and `m_ready` are both 1, `m_valid` is 0 in the next cycle. `m_valid` never falls without such a handshake.
- R7: `s_valid` and `s_data` are ignored while `s_ready` is 0. No extra word is ever delivered, and `m_valid` stays 0 once all accepted words have been taken.
- R8: Delivery is complete and ordered both when `m_clk` is much slower than `s_clk` and when it is much faster. The synchroniser depth `SYNC_STAGES` defaults to 2 and is raised to 2 when it is set lower.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| s_clk | input | 1 | Source-side clock |
| s_rst_n | input | 1 | Source-side asynchronous reset, active low, released in step with `s_clk` |
| s_valid | input | 1 | Source offers a word |
| s_ready | output | 1 | Bridge can take a word this cycle |
| s_data | input | DATA_W | Word offered by the source |
| m_clk | input | 1 | Destination-side clock |
| m_rst_n | input | 1 | Destination-side asynchronous reset, active low, released in step with `m_clk` |
| m_valid | output | 1 | A word is waiting on `m_data` |
| m_ready | input | 1 | Consumer takes the word this cycle |
| m_data | output | DATA_W | Word presented to the consumer |

## Verification
On every cycle the bound checker enforces the single-domain rules. These are the drop of `s_ready` after an accept, the holding of `m_valid` and `m_data` under a stall, and the fall of `m_valid` only after a handshake. Several properties cannot be seen within one clock domain: the round trip that restores `s_ready`, the order and values of delivered words, the rejection of offers made while `s_ready` is low, and correct operation under both clock ratios. The scoreboard bench shows these in its scenarios. It runs long stalls, throttled and continuous consumers, and junk offered during busy periods, first with a slow destination clock and then with a fast one.

// File: rtl/hs_cdc_pkg.sv
package hs_cdc_pkg;
  // Smallest flop chain accepted for a toggle crossing.
  localparam int MIN_SYNC_STAGES = 2;

  // Two toggle bits that differ mean a word is outstanding.
  function automatic logic tgl_differ(input logic own_tgl, input logic far_tgl);
    return own_tgl ^ far_tgl;
  endfunction
endpackage

// File: rtl/hs_sync_chain.sv
module hs_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/hs_src_side.sv
module hs_src_side
  import hs_cdc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STAGES = 2
) (
  input  logic              s_clk,
  input  logic              s_rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              ack_tgl_async,
  output logic              req_tgl,
  output logic [DATA_W-1:0] hold_data
);
  logic ack_seen;
  logic req_q, req_d;
  logic take;
  logic [DATA_W-1:0] word_q, word_d;

  hs_sync_chain #(.STAGES(STAGES)) u_ack_sync (
    .clk  (s_clk),
    .rst_n(s_rst_n),
    .d    (ack_tgl_async),
    .q    (ack_seen)
  );

  always_comb begin
    s_ready = !tgl_differ(req_q, ack_seen);
    take    = s_valid && s_ready;
    req_d   = req_q ^ take;
    word_d  = take ? s_data : word_q;
  end

  always_ff @(posedge s_clk or negedge s_rst_n) begin
    if (!s_rst_n) begin
      req_q  <= 1'b0;
      word_q <= '0;
    end else begin
      req_q  <= req_d;
      word_q <= word_d;
    end
  end

  assign req_tgl   = req_q;
  assign hold_data = word_q;
endmodule

// File: rtl/hs_dst_side.sv
module hs_dst_side
  import hs_cdc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STAGES = 2
) (
  input  logic              m_clk,
  input  logic              m_rst_n,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  input  logic              req_tgl_async,
  input  logic [DATA_W-1:0] word_async,
  output logic              ack_tgl
);
  logic req_seen;
  logic ack_q, ack_d;
  logic [DATA_W-1:0] out_q, out_d;

  hs_sync_chain #(.STAGES(STAGES)) u_req_sync (
    .clk  (m_clk),
    .rst_n(m_rst_n),
    .d    (req_tgl_async),
    .q    (req_seen)
  );

  always_comb begin
    m_valid = tgl_differ(ack_q, req_seen);
    ack_d   = ack_q ^ (m_valid && m_ready);
    // Capture only while no word is presented; the source word is
    // held still from before the request toggle crosses.
    out_d   = m_valid ? out_q : word_async;
  end

  always_ff @(posedge m_clk or negedge m_rst_n) begin
    if (!m_rst_n) begin
      ack_q <= 1'b0;
      out_q <= '0;
    end else begin
      ack_q <= ack_d;
      out_q <= out_d;
    end
  end

  assign m_data  = out_q;
  assign ack_tgl = ack_q;
endmodule

// File: rtl/hs_cdc_bridge.sv
module hs_cdc_bridge
  import hs_cdc_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              s_clk,
  input  logic              s_rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              m_clk,
  input  logic              m_rst_n,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data
);
  // R8: depth below the safe minimum is raised to it.
  localparam int EFF_STAGES = (SYNC_STAGES < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : SYNC_STAGES;

  logic              req_tgl;
  logic              ack_tgl;
  logic [DATA_W-1:0] hold_data;

  hs_src_side #(.DATA_W(DATA_W), .STAGES(EFF_STAGES)) u_src (
    .s_clk        (s_clk),
    .s_rst_n      (s_rst_n),
    .s_valid      (s_valid),
    .s_ready      (s_ready),
    .s_data       (s_data),
    .ack_tgl_async(ack_tgl),
    .req_tgl      (req_tgl),
    .hold_data    (hold_data)
  );

  hs_dst_side #(.DATA_W(DATA_W), .STAGES(EFF_STAGES)) u_dst (
    .m_clk        (m_clk),
    .m_rst_n      (m_rst_n),
    .m_valid      (m_valid),
    .m_ready      (m_ready),
    .m_data       (m_data),
    .req_tgl_async(req_tgl),
    .word_async   (hold_data),
    .ack_tgl      (ack_tgl)
  );
endmodule

// File: rtl/hs_cdc_bridge_chk.sv
module hs_cdc_bridge_chk #(
  parameter int DATA_W = 32
) (
  input logic              s_clk,
  input logic              s_rst_n,
  input logic              s_valid,
  input logic              s_ready,
  input logic              m_clk,
  input logic              m_rst_n,
  input logic              m_valid,
  input logic              m_ready,
  input logic [DATA_W-1:0] m_data
);
  assert_ready_drop_R2: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    (s_valid && s_ready) |=> !s_ready);

  assert_stall_hold_R5: assert property (@(posedge m_clk) disable iff (!m_rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  assert_release_R6: assert property (@(posedge m_clk) disable iff (!m_rst_n)
    (m_valid && m_ready) |=> !m_valid);

  assert_fall_on_ack_R6: assert property (@(posedge m_clk) disable iff (!m_rst_n)
    $fell(m_valid) |-> $past(m_ready));
endmodule

bind hs_cdc_bridge hs_cdc_bridge_chk #(.DATA_W(DATA_W)) u_chk (
  .s_clk  (s_clk),
  .s_rst_n(s_rst_n),
  .s_valid(s_valid),
  .s_ready(s_ready),
  .m_clk  (m_clk),
  .m_rst_n(m_rst_n),
  .m_valid(m_valid),
  .m_ready(m_ready),
  .m_data (m_data)
);

// File: tb/tb_hs_cdc_bridge.sv
`timescale 1ns/1ps
module tb_hs_cdc_bridge;
  localparam int W = 16;

  logic         s_clk = 1'b0;
  logic         m_clk = 1'b0;
  logic         s_rst_n, m_rst_n;
  logic         s_valid, m_ready;
  logic [W-1:0] s_data;
  logic         s_ready, m_valid;
  logic [W-1:0] m_data;

  int checks = 0;
  int errors = 0;
  int m_half = 23;

  hs_cdc_bridge #(.DATA_W(W), .SYNC_STAGES(2)) dut (
    .s_clk(s_clk), .s_rst_n(s_rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_clk(m_clk), .m_rst_n(m_rst_n), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
  );

  always #10 s_clk = ~s_clk;            // 50 MHz source clock
  initial forever #(m_half) m_clk = ~m_clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Scoreboard
  logic [W-1:0] expq[$];
  int  sent = 0, delivered = 0;
  int  ready_mode = 0;   // 0 always ready, 1 stalled, 2 throttled
  int  mcnt = 0;
  bit  mon_en = 0, was_stall = 0, ack_prev = 0;
  logic [W-1:0] last_data, expd;

  always @(negedge m_clk) begin
    if (!mon_en) begin
      m_ready   = 1'b0;
      was_stall = 0;
      ack_prev  = 0;
    end else begin
      mcnt++;
      case (ready_mode)
        0:       m_ready = 1'b1;
        1:       m_ready = 1'b0;
        default: m_ready = (mcnt % 3 != 0);
      endcase
      if (ack_prev) chk(!m_valid, "R6 valid drops after handshake", m_valid, 0);
      if (was_stall) chk(m_valid && m_data == last_data, "R5 hold under stall", m_data, last_data);
      was_stall = m_valid && !m_ready;
      ack_prev  = m_valid && m_ready;
      last_data = m_data;
      if (m_valid && m_ready) begin
        delivered++;
        if (expq.size() == 0) chk(0, "R7 extra word delivered", m_data, 0);
        else begin
          expd = expq.pop_front();
          chk(m_data == expd, "R4 word value/order", m_data, expd);
        end
      end
    end
  end

  task automatic send(input logic [W-1:0] d, input bit junk);
    @(negedge s_clk);
    s_valid = 1'b1;
    s_data  = d;
    while (!s_ready) @(negedge s_clk);
    expq.push_back(d);
    sent++;
    @(negedge s_clk);
    s_valid = 1'b0;
    chk(!s_ready, "R2 ready low after accept", s_ready, 0);
    if (junk) begin
      // R7: offers while s_ready is low must be ignored
      s_valid = 1'b1;
      s_data  = ~d;
      forever begin
        @(negedge s_clk);
        if (s_ready) begin
          s_valid = 1'b0;
          break;
        end
        s_data = s_data + 16'h0101;
      end
    end
  endtask

  task automatic do_reset();
    mon_en  = 0;
    s_valid = 1'b0;
    s_data  = '0;
    s_rst_n = 1'b0;
    m_rst_n = 1'b0;
    repeat (4) @(negedge s_clk);
    repeat (2) @(negedge m_clk);
    chk(s_ready == 1'b1, "R1 s_ready in reset", s_ready, 1);
    chk(m_valid == 1'b0, "R1 m_valid in reset", m_valid, 0);
    @(negedge m_clk) m_rst_n = 1'b1;
    @(negedge s_clk) s_rst_n = 1'b1;
    mon_en = 1;
    repeat (3) @(negedge s_clk);
    chk(s_ready == 1'b1, "R1 s_ready after release", s_ready, 1);
    chk(m_valid == 1'b0, "R1 m_valid after release", m_valid, 0);
  endtask

  task automatic drain(input int phase);
    while (expq.size() != 0) @(negedge s_clk);
    repeat (12) @(negedge s_clk);
    chk(s_ready == 1'b1, "R3 ready returns after ack", s_ready, 1);
    chk(m_valid == 1'b0, "R7 idle after last word", m_valid, 0);
    chk(delivered == sent, $sformatf("R8 all words delivered, phase %0d", phase), delivered, sent);
  endtask

  initial begin
    for (int phase = 0; phase < 2; phase++) begin
      m_half = (phase == 0) ? 23 : 3;     // slow then fast destination
      sent = 0;
      delivered = 0;
      ready_mode = 0;
      do_reset();
      // continuous consumer, incrementing words
      for (int i = 0; i < 8; i++) send(W'(16'h1000 * phase + i), 1'b0);
      // throttled consumer with junk offered during busy periods
      ready_mode = 2;
      send(16'hFFFF, 1'b1);
      send(16'h0000, 1'b1);
      send(16'hA5A5, 1'b1);
      send(16'h5A5A, 1'b1);
      drain(phase);
      // R3: stalled consumer keeps the source blocked
      ready_mode = 1;
      send(16'hC3C3, 1'b0);
      for (int k = 0; k < 30; k++) begin
        @(negedge s_clk);
        chk(!s_ready, "R3 ready stays low while word pending", s_ready, 0);
      end
      chk(m_valid && m_data == 16'hC3C3, "R4 pending word presented", m_data, 16'hC3C3);
      ready_mode = 0;
      drain(phase);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge s_clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual %0d expected %0d", sent, delivered);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule